// File: doc/BRIEF.md
# Two-Phase Mailbox Bootstrap Register

This block is the device end of a single 32-bit doorbell register. A host uses it to hand over the location of a command mailbox before any command rings have been set up. The host writes the register twice. The first write has the phase flag set and carries the upper 30 bits of the mailbox address. The second write has the phase flag clear and carries the lower 30 bits. After each write the host polls the ready bit before it does anything else.

The block accepts the first half and acknowledges it by raising ready. On the second write it joins both halves into a 16-byte-aligned 64-bit address. It then issues a one-cycle start pulse toward the agent that executes the command. When that agent returns a one-cycle done pulse, the block raises ready to show that the mailbox now holds a valid completion entry. A write that breaks the expected order sets a sticky sequence-error flag, which only reset clears.

Register fields: ready in bit 0 (read-only), phase flag in bit 1 (1 selects the upper half), address field in bits 31:2.

Top module: `mbx_boot_reg`

## Requirements
- R1: After reset, `rd_data` is all zero, `seq_err` is 0 and `cmd_start` is 0.
- R2: Any accepted write clears ready (bit 0 of `rd_data`) in the cycle after the write. After an upper-half write (bit 1 = 1), ready reads 1 one cycle after that.
- R3: A lower-half write (bit 1 = 0) made while an upper half is held produces `cmd_start` high for exactly one cycle, in the cycle after the write. In that cycle `cmd_addr` equals {upper field, lower field, 4'b0000}.
- R4: Ready stays 0 while a command is executing. It reads 1 in the cycle after `cmd_done` is seen during execution.
- R5: A lower-half write with no upper half held sets `seq_err`, produces no `cmd_start`, and leaves ready at 0.
- R6: Any write while a command is executing is ignored: `cmd_addr` and `rd_data` bits 31:1 are unchanged and ready stays 0. The write also sets `seq_err`.
- R7: Bit 0 of written data has no effect. Ready and the command sequence behave as if that bit were 0.
- R8: `seq_err` stays set until reset, including across later correct sequences.
- R9: `rd_data` bits 31:1 return bits 31:1 of the last accepted write, and bit 0 returns ready.
- R10: Repeated upper-half writes before the lower half are allowed. The most recent upper field is the one used in `cmd_addr`.
- R11: `cmd_done` received while no command is executing has no effect on ready or `seq_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | 32 | Host write data: bit 1 phase flag, bits 31:2 address field |
| cmd_done | input | 1 | One-cycle completion pulse from the executing agent |
| rd_data | output | 32 | Register readback: bit 0 ready, bits 31:1 last accepted write |
| seq_err | output | 1 | Sticky sequence-error flag |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_addr | output | 64 | Assembled, 16-byte-aligned mailbox address |

## Verification
The hardest situation to reach is a write that lands while a command is executing. Reaching it takes a complete, correctly ordered two-phase sequence, and the agent's done pulse must be held back. The stimulus launches a command and then issues an upper-half write carrying a different address before pulsing `cmd_done`. It then checks that the address and readback are unchanged, that the error flag is set, and that completion still raises ready. A further sequence run after that error shows that the flag stays set.

// File: rtl/mbx_boot_pkg.sv
// Shared definitions for the mailbox bootstrap register.
// Assumes one 32-bit register: bit 0 ready, bit 1 phase flag, above that the address field.
package mbx_boot_pkg;
    localparam int RDY_BIT   = 0;
    localparam int PHASE_BIT = 1;
    localparam int FIELD_LSB = 2;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_HI_PEND = 2'd1,
        PH_HI_HELD = 2'd2,
        PH_BUSY    = 2'd3
    } mbx_phase_e;
endpackage

// File: rtl/mbx_seq_ctrl.sv
// Phase sequencer: tracks which half has arrived, owns the ready bit, the
// sticky error flag and the start pulse. Produces capture strobes for the
// address assembler. Assumes cmd_done is a single-cycle pulse.
module mbx_seq_ctrl
    import mbx_boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_phase_hi,
    input  logic cmd_done,
    output logic cap_upper,
    output logic cap_lower,
    output logic ready,
    output logic seq_err,
    output logic cmd_start
);
    mbx_phase_e phase_q;
    logic       half_held;
    logic       bad_write;

    // Decode which writes are accepted and which break the sequence.
    always_comb begin
        half_held = (phase_q == PH_HI_PEND) || (phase_q == PH_HI_HELD);
        cap_upper = wr_en && wr_phase_hi && (phase_q != PH_BUSY);
        cap_lower = wr_en && !wr_phase_hi && half_held;
        bad_write = wr_en && ((phase_q == PH_BUSY) ||
                              (!wr_phase_hi && (phase_q == PH_IDLE)));
    end

    // Phase state, ready bit, start pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            ready     <= 1'b0;
            seq_err   <= 1'b0;
            cmd_start <= 1'b0;
        end else begin
            cmd_start <= cap_lower;
            seq_err   <= seq_err | bad_write;
            case (phase_q)
                PH_IDLE: begin
                    if (wr_en) ready <= 1'b0;
                    if (cap_upper) phase_q <= PH_HI_PEND;
                end
                PH_HI_PEND, PH_HI_HELD: begin
                    if (cap_lower) begin
                        ready   <= 1'b0;
                        phase_q <= PH_BUSY;
                    end else if (cap_upper) begin
                        ready   <= 1'b0;
                        phase_q <= PH_HI_PEND;
                    end else if (phase_q == PH_HI_PEND) begin
                        ready   <= 1'b1;
                        phase_q <= PH_HI_HELD;
                    end
                end
                default: begin
                    if (cmd_done) begin
                        ready   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mbx_addr_asm.sv
// Address assembler: holds the upper and lower address fields and the
// readback shadow, and joins the fields into the aligned command address.
// Assumes a capture strobe is only raised for an accepted write.
module mbx_addr_asm #(
    parameter int FIELD_W = 30,
    parameter int ALIGN_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_upper,
    input  logic                       cap_lower,
    input  logic [FIELD_W+1:0]         wr_data,
    output logic [FIELD_W:0]           shadow,
    output logic [2*FIELD_W+ALIGN_W-1:0] cmd_addr
);
    localparam int ADDR_W = 2 * FIELD_W + ALIGN_W;

    logic [FIELD_W-1:0] upper_q;
    logic [FIELD_W-1:0] lower_q;

    // Capture address halves and the readback image of accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            shadow  <= '0;
        end else begin
            if (cap_upper) upper_q <= wr_data[FIELD_W+1:2];
            if (cap_lower) lower_q <= wr_data[FIELD_W+1:2];
            if (cap_upper || cap_lower) shadow <= wr_data[FIELD_W+1:1];
        end
    end

    // Join the halves, padding the alignment bits when there are any.
    generate
        if (ALIGN_W > 0) begin : g_pad
            assign cmd_addr = {upper_q, lower_q, {ALIGN_W{1'b0}}};
        end else begin : g_nopad
            assign cmd_addr = {upper_q, lower_q};
        end
    endgenerate

    logic unused_w;
    assign unused_w = ^ADDR_W;
endmodule

// File: rtl/mbx_boot_reg.sv
// Top of the two-phase mailbox bootstrap register. Register layout:
// bit 0 ready (read-only), bit 1 phase flag, upper bits address field.
// Assumes the host polls ready between writes.
module mbx_boot_reg #(
    parameter int FIELD_W = 30,
    parameter int ALIGN_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [FIELD_W+1:0]           wr_data,
    input  logic                         cmd_done,
    output logic [FIELD_W+1:0]           rd_data,
    output logic                         seq_err,
    output logic                         cmd_start,
    output logic [2*FIELD_W+ALIGN_W-1:0] cmd_addr
);
    import mbx_boot_pkg::*;

    logic             cap_upper;
    logic             cap_lower;
    logic             ready;
    logic [FIELD_W:0] shadow;

    mbx_seq_ctrl u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_phase_hi (wr_data[PHASE_BIT]),
        .cmd_done    (cmd_done),
        .cap_upper   (cap_upper),
        .cap_lower   (cap_lower),
        .ready       (ready),
        .seq_err     (seq_err),
        .cmd_start   (cmd_start)
    );

    mbx_addr_asm #(.FIELD_W(FIELD_W), .ALIGN_W(ALIGN_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_upper (cap_upper),
        .cap_lower (cap_lower),
        .wr_data   (wr_data),
        .shadow    (shadow),
        .cmd_addr  (cmd_addr)
    );

    // Readback image: shadow above, live ready in bit 0.
    assign rd_data = {shadow, ready};
endmodule

// File: rtl/mbx_boot_chk.sv
// Property checker for the mailbox bootstrap register, bound to the top.
// Keeps its own view of whether a command is executing.
module mbx_boot_chk #(
    parameter int FIELD_W = 30,
    parameter int ALIGN_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [FIELD_W+1:0]           wr_data,
    input logic                         cmd_done,
    input logic [FIELD_W+1:0]           rd_data,
    input logic                         seq_err,
    input logic                         cmd_start,
    input logic [2*FIELD_W+ALIGN_W-1:0] cmd_addr
);
    logic busy_q;
    logic busy_now;

    assign busy_now = busy_q || cmd_start;

    // Track command execution from the start pulse to the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else if (cmd_done && busy_now) busy_q <= 1'b0;
        else if (cmd_start) busy_q <= 1'b1;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start); // R3
    AST_START_AFTER_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> $past(wr_en && !wr_data[1])); // R3
    AST_NOT_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_now |-> !rd_data[0]); // R4
    AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_now && cmd_done) |=> rd_data[0]); // R4
    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(busy_now && cmd_done)) |=> !rd_data[0]); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err); // R8
    AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_now && wr_en) |=> seq_err); // R6
    AST_ADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> $stable(cmd_addr)); // R6
endmodule

bind mbx_boot_reg mbx_boot_chk #(.FIELD_W(FIELD_W), .ALIGN_W(ALIGN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cmd_done  (cmd_done),
    .rd_data   (rd_data),
    .seq_err   (seq_err),
    .cmd_start (cmd_start),
    .cmd_addr  (cmd_addr)
);

// File: tb/mbx_boot_reg_test.sv
`timescale 1ns/1ps
module mbx_boot_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cmd_done = 1'b0;
    logic [31:0] rd_data;
    logic        seq_err;
    logic        cmd_start;
    logic [63:0] cmd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mbx_boot_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_done(cmd_done), .rd_data(rd_data), .seq_err(seq_err),
        .cmd_start(cmd_start), .cmd_addr(cmd_addr)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] d;
        logic        done;
        logic        ready;
        logic        start;
        logic        err;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, {30'h1234_5678, 2'b10}, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 upper write clears ready
        '{1'b0, 32'h0,                  1'b0, 1'b1, 1'b0, 1'b0}, // R2 acknowledge
        '{1'b1, {30'h0765_4321, 2'b00}, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 launch
        '{1'b0, 32'h0,                  1'b0, 1'b0, 1'b0, 1'b0}, // R4 busy, not ready
        '{1'b0, 32'h0,                  1'b1, 1'b1, 1'b0, 1'b0}, // R4 done
        '{1'b0, 32'h0,                  1'b0, 1'b1, 1'b0, 1'b0}, // R4 ready holds
        '{1'b1, {30'h0000_0011, 2'b00}, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 lone lower write
        '{1'b0, 32'h0,                  1'b0, 1'b0, 1'b0, 1'b1}  // R8 flag holds
    };

    localparam logic [29:0] UA = 30'h2AAA_5555;
    localparam logic [29:0] UB = 30'h1357_9BDF;
    localparam logic [29:0] LA = 30'h0F0F_0F0F;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic we, input logic [31:0] d, input logic done);
        @(negedge clk);
        wr_en = we; wr_data = d; cmd_done = done;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_data = '0; cmd_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; cmd_done = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        check("R1", "rd_data", rd_data, 0);
        check("R1", "seq_err", seq_err, 0);
        check("R1", "cmd_start", cmd_start, 0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            step(VECS[i].we, VECS[i].d, VECS[i].done);
            check($sformatf("row%0d", i), "ready", rd_data[0], VECS[i].ready);
            check($sformatf("row%0d", i), "cmd_start", cmd_start, VECS[i].start);
            check($sformatf("row%0d", i), "seq_err", seq_err, VECS[i].err);
        end

        // R1 and R8: reset clears the sticky flag
        do_reset();
        check("R1", "rd_data after reset", rd_data, 0);
        check("R8", "seq_err cleared by reset", seq_err, 0);

        // R3 / R9: address assembly and readback
        step(1'b1, {UA, 2'b10}, 1'b0);
        check("R2", "ready after upper write", rd_data[0], 0);
        step(1'b0, 32'h0, 1'b0);
        check("R9", "readback after ack", rd_data, {UA, 2'b11});
        step(1'b1, {LA, 2'b00}, 1'b0);
        check("R3", "start pulse", cmd_start, 1);
        check("R3", "cmd_addr", cmd_addr, {UA, LA, 4'h0});
        check("R9", "readback after lower", rd_data, {LA, 2'b00});

        // R6: write while executing is ignored and flagged
        step(1'b1, {UB, 2'b10}, 1'b0);
        check("R6", "seq_err", seq_err, 1);
        check("R6", "rd_data unchanged", rd_data, {LA, 2'b00});
        check("R6", "cmd_addr unchanged", cmd_addr, {UA, LA, 4'h0});
        check("R3", "single-cycle start", cmd_start, 0);
        step(1'b0, 32'h0, 1'b1);
        check("R4", "ready after done", rd_data[0], 1);

        // R8: flag stays set through a correct sequence
        step(1'b1, {UA, 2'b10}, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        step(1'b1, {LA, 2'b00}, 1'b0);
        check("R8", "start still works", cmd_start, 1);
        check("R8", "seq_err sticky", seq_err, 1);
        step(1'b0, 32'h0, 1'b1);

        // R7: bit 0 of write data is ignored
        do_reset();
        step(1'b1, {UA, 2'b11}, 1'b0);
        check("R7", "ready after upper write with bit0", rd_data[0], 0);
        step(1'b0, 32'h0, 1'b0);
        check("R7", "ack with bit0", rd_data[0], 1);
        step(1'b1, {LA, 2'b01}, 1'b0);
        check("R7", "readback lower with bit0", rd_data, {LA, 2'b00});
        check("R7", "start with bit0", cmd_start, 1);
        step(1'b0, 32'h0, 1'b1);

        // R10: latest upper half wins
        do_reset();
        step(1'b1, {UA, 2'b10}, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        step(1'b1, {UB, 2'b10}, 1'b0);
        check("R10", "ready cleared by second upper", rd_data[0], 0);
        step(1'b0, 32'h0, 1'b0);
        step(1'b1, {LA, 2'b00}, 1'b0);
        check("R10", "cmd_addr uses latest upper", cmd_addr, {UB, LA, 4'h0});
        check("R10", "no error", seq_err, 0);
        step(1'b0, 32'h0, 1'b1);
        check("R4", "ready after done", rd_data[0], 1);

        // R11: stray done pulses
        step(1'b0, 32'h0, 1'b1);
        check("R11", "ready kept after stray done", rd_data[0], 1);
        check("R11", "no error after stray done", seq_err, 0);
        do_reset();
        step(1'b0, 32'h0, 1'b1);
        check("R11", "ready stays 0 on idle done", rd_data[0], 0);
        check("R11", "seq_err on idle done", seq_err, 0);

        summary();
    end
endmodule